// File: doc/BRIEF.md
# Secured configuration readback controller

This block guards the configuration store of a programmable logic array. The store holds three things: a fuse map of addressable words, a 64-bit user signature kept as eight bytes, and a single security bit. A host issues one command at a time over a valid/ready handshake. The commands write or verify fuse words, read or write signature bytes, ask for a register preload, set the security bit, or wipe the whole store. Each accepted command produces one response, which carries read data and an inhibit flag.

The security bit acts on the next command it sees. Once it is set, the controller refuses fuse verify reads, fuse writes and preload requests. It answers each refused command with zero data and a raised inhibit flag. The signature stays readable and writable whatever the state of the security bit. Only the erase command clears the security bit, and erase also clears the fuse map and the signature. For this reason the security bit is normally the last thing a host programs.

Top module: `cfg_vault`

## Requirements
- R1: After reset every fuse word and every signature byte read as zero, `secured` is low, `rsp_valid` and `preload_valid` are low, and `cmd_ready` is high.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `rsp_valid` is high for exactly the one cycle that follows the acceptance. `cmd_ready` is low during that response cycle.
- R3: With `secured` low, op 0 stores `cmd_wdata` into the fuse word at `cmd_addr`, and op 1 returns that fuse word in `rsp_data`.
- R4: Op 2 stores `cmd_wdata` into the signature byte selected by `cmd_addr[2:0]`. Op 3 returns that byte. Both work the same way whether or not `secured` is set.
- R5: Op 5 raises `secured` from the cycle after acceptance onward. The bit stays high through every command except op 6.
- R6: While `secured` is high, ops 0, 1 and 4 change no state and emit no preload pulse. Their response carries `rsp_data` of zero with `rsp_inhibit` high for that single response cycle.
- R7: With `secured` low, op 4 pulses `preload_valid` in the response cycle, with `preload_addr` equal to `cmd_addr` and `preload_data` equal to `cmd_wdata`.
- R8: Op 6 clears every fuse word, every signature byte and `secured`, even when the device is secured.
- R9: Op 7 is reserved. It changes no state and answers with zero data and no inhibit.
- R10: Writes, preload, secure and erase answer with `rsp_data` of zero. `rsp_inhibit` is high only in the case R6 describes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, returns the store to its erased state |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller can accept a command |
| cmd_op | input | 3 | Opcode: 0 fuse write, 1 fuse read, 2 signature write, 3 signature read, 4 preload, 5 secure, 6 erase, 7 reserved |
| cmd_addr | input | ADDR_W | Fuse word address or signature byte index |
| cmd_wdata | input | DATA_W | Write or preload data |
| rsp_valid | output | 1 | Response cycle |
| rsp_data | output | DATA_W | Read data, zero for non-read or inhibited commands |
| rsp_inhibit | output | 1 | Command was refused by the security bit |
| preload_valid | output | 1 | Preload request pulse |
| preload_addr | output | ADDR_W | Register index to preload |
| preload_data | output | DATA_W | Value to preload |
| secured | output | 1 | Security bit state |

## Verification
The bench builds the block with its default parameters: sixteen 8-bit fuse words and eight signature bytes. With so small a store, a few hundred random commands revisit each address many times. Secure and erase commands appear often enough that the random sequence keeps crossing between the secured and unsecured states. This lets inhibited writes be checked against later reads made after an erase, and lets signature accesses be checked on both sides of the security bit.

// File: rtl/cfg_vault.sv
module cfg_vault #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int SIG_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_inhibit,
  output logic              preload_valid,
  output logic [ADDR_W-1:0] preload_addr,
  output logic [DATA_W-1:0] preload_data,
  output logic              secured
);
  localparam int FUSE_WORDS = 1 << ADDR_W;
  localparam int SIG_BYTES  = SIG_W / DATA_W;
  localparam int SIG_AW     = $clog2(SIG_BYTES);

  localparam logic [2:0] OP_FUSE_WR = 3'd0;
  localparam logic [2:0] OP_FUSE_RD = 3'd1;
  localparam logic [2:0] OP_SIG_WR  = 3'd2;
  localparam logic [2:0] OP_SIG_RD  = 3'd3;
  localparam logic [2:0] OP_PRELOAD = 3'd4;
  localparam logic [2:0] OP_SECURE  = 3'd5;
  localparam logic [2:0] OP_ERASE   = 3'd6;

  logic [DATA_W-1:0] fuse_q [FUSE_WORDS];
  logic [DATA_W-1:0] sig_q  [SIG_BYTES];
  logic              accept, guarded, blocked;
  logic [SIG_AW-1:0] sig_idx;
  logic [DATA_W-1:0] rd_val;

  assign cmd_ready = ~rsp_valid;
  assign accept    = cmd_valid & cmd_ready;
  assign sig_idx   = cmd_addr[SIG_AW-1:0];
  assign guarded   = (cmd_op == OP_FUSE_WR) | (cmd_op == OP_FUSE_RD) | (cmd_op == OP_PRELOAD);
  assign blocked   = secured & guarded;

  always_comb begin
    rd_val = '0;
    if (cmd_op == OP_FUSE_RD && !blocked) rd_val = fuse_q[cmd_addr];
    else if (cmd_op == OP_SIG_RD)         rd_val = sig_q[sig_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_data      <= '0;
      rsp_inhibit   <= 1'b0;
      preload_valid <= 1'b0;
      preload_addr  <= '0;
      preload_data  <= '0;
      secured       <= 1'b0;
      for (int i = 0; i < FUSE_WORDS; i++) fuse_q[i] <= '0;
      for (int i = 0; i < SIG_BYTES; i++)  sig_q[i]  <= '0;
    end else begin
      rsp_valid     <= accept;
      rsp_data      <= accept ? rd_val : '0;
      rsp_inhibit   <= accept & blocked;
      preload_valid <= accept & ~blocked & (cmd_op == OP_PRELOAD);
      if (accept && !blocked && cmd_op == OP_PRELOAD) begin
        preload_addr <= cmd_addr;
        preload_data <= cmd_wdata;
      end
      if (accept && !blocked) begin
        case (cmd_op)
          OP_FUSE_WR: fuse_q[cmd_addr] <= cmd_wdata;
          OP_SIG_WR:  sig_q[sig_idx]   <= cmd_wdata;
          OP_SECURE:  secured          <= 1'b1;
          OP_ERASE: begin
            secured <= 1'b0;
            for (int i = 0; i < FUSE_WORDS; i++) fuse_q[i] <= '0;
            for (int i = 0; i < SIG_BYTES; i++)  sig_q[i]  <= '0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module cfg_vault_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_inhibit,
  input logic              preload_valid,
  input logic              secured
);
  a_r2_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> rsp_valid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready) |=> !rsp_valid);
  a_r6_inhibit_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_inhibit |-> (rsp_valid && rsp_data == '0));
  a_r6_inhibit_only_secured: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd1 && secured) |=> (rsp_inhibit && rsp_data == '0));
  a_r7_preload_unsecured: assert property (@(posedge clk) disable iff (!rst_n)
    preload_valid |-> (rsp_valid && !rsp_inhibit && $past(!secured)));
  a_r5_secure_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (secured && !(cmd_valid && cmd_ready && cmd_op == 3'd6)) |=> secured);
  a_r5_secure_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd5) |=> secured);
endmodule

bind cfg_vault cfg_vault_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .rsp_inhibit(rsp_inhibit), .preload_valid(preload_valid), .secured(secured)
);

// File: tb/sim_cfg_vault.sv
module sim_cfg_vault;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NF = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          rsp_valid, rsp_inhibit, preload_valid, secured;
  logic [DW-1:0] rsp_data, preload_data;
  logic [AW-1:0] preload_addr;

  int checks = 0;
  int failures = 0;

  logic [DW-1:0] m_fuse [NF];
  logic [DW-1:0] m_sig  [8];
  logic          m_sec;

  always #10 clk = ~clk;

  cfg_vault u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_inhibit(rsp_inhibit),
    .preload_valid(preload_valid), .preload_addr(preload_addr),
    .preload_data(preload_data), .secured(secured)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(logic [2:0] op, logic sec);
    if (sec && (op == 3'd0 || op == 3'd1 || op == 3'd4)) return "R6";
    case (op)
      3'd0, 3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd4:       return "R7";
      3'd5:       return "R5";
      3'd6:       return "R8";
      default:    return "R9";
    endcase
  endfunction

  function automatic logic [DW-1:0] exp_data(logic [2:0] op, logic [AW-1:0] a);
    if (op == 3'd1 && !m_sec) return m_fuse[a];
    if (op == 3'd3)           return m_sig[a[2:0]];
    return '0;
  endfunction

  task automatic run(logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] wd);
    string tag;
    logic blk;
    logic [DW-1:0] ed;
    tag = op_tag(op, m_sec);
    blk = m_sec && (op == 3'd0 || op == 3'd1 || op == 3'd4);
    ed  = exp_data(op, a);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!blk) begin
      case (op)
        3'd0: m_fuse[a] = wd;
        3'd2: m_sig[a[2:0]] = wd;
        3'd5: m_sec = 1'b1;
        3'd6: begin
          m_sec = 1'b0;
          for (int i = 0; i < NF; i++) m_fuse[i] = '0;
          for (int i = 0; i < 8; i++)  m_sig[i]  = '0;
        end
        default: ;
      endcase
    end
    check({"R2 rsp_valid ", tag}, rsp_valid, 1);
    check({"R2 ready low ", tag}, cmd_ready, 0);
    check({"R10 rsp_data ", tag}, rsp_data, ed);
    check({"R10 inhibit ", tag}, rsp_inhibit, blk);
    check({"R7 preload_valid ", tag}, preload_valid, (op == 3'd4) && !blk);
    if (op == 3'd4 && !blk) begin
      check("R7 preload_addr", preload_addr, a);
      check("R7 preload_data", preload_data, wd);
    end
    check({"R5 secured ", tag}, secured, m_sec);
    @(negedge clk);
    check({"R2 single rsp ", tag}, rsp_valid, 0);
    check({"R7 single preload ", tag}, preload_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_sec = 1'b0;
    for (int i = 0; i < NF; i++) m_fuse[i] = '0;
    for (int i = 0; i < 8; i++)  m_sig[i]  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 ready", cmd_ready, 1);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 preload_valid", preload_valid, 0);
    check("R1 secured", secured, 0);
    for (int i = 0; i < NF; i++) run(3'd1, AW'(i), '0);
    for (int i = 0; i < 8; i++)  run(3'd3, AW'(i), '0);

    run(3'd0, 4'd3, 8'hA5);
    run(3'd1, 4'd3, 8'h00);
    run(3'd2, 4'd7, 8'h3C);
    run(3'd4, 4'd9, 8'h5A);
    run(3'd7, 4'd3, 8'hFF);
    run(3'd1, 4'd3, 8'h00);
    run(3'd5, 4'd0, 8'h00);
    run(3'd1, 4'd3, 8'h00);
    run(3'd0, 4'd3, 8'h11);
    run(3'd4, 4'd2, 8'h77);
    run(3'd3, 4'd7, 8'h00);
    run(3'd2, 4'd1, 8'hC3);
    run(3'd3, 4'd1, 8'h00);
    run(3'd6, 4'd0, 8'h00);
    run(3'd1, 4'd3, 8'h00);
    run(3'd3, 4'd7, 8'h00);

    for (int n = 0; n < 600; n++) begin
      int r;
      logic [2:0] op;
      r = $urandom % 20;
      if (r < 4)       op = 3'd0;
      else if (r < 7)  op = 3'd1;
      else if (r < 9)  op = 3'd2;
      else if (r < 12) op = 3'd3;
      else if (r < 14) op = 3'd4;
      else if (r < 16) op = 3'd5;
      else if (r < 17) op = 3'd6;
      else if (r < 18) op = 3'd7;
      else             op = 3'd1;
      run(op, AW'($urandom), DW'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule